// File: doc/BRIEF.md
# Memory Error Capture Lock Register

This block holds a frozen record of what the memory controller was doing when the first error in a burst of trouble was raised. Error sources raise bits in a small error-status register. The first raised bit copies several values into a 32-bit capture word: the live sequencer state code, the data-cycle type code, the beat index within the burst, the upper address bits and the one-hot set of nonexistent-memory flags. The capture word then stays locked. Later errors still raise status bits, but they do not disturb the record.

Software reads the capture word. It clears status bits by writing ones to them. When no status bit remains set, the lock opens, and from then on the capture word has no defined content until the next error. The block also returns the low two bits of the failing beat's location. It forms them from the captured address bits 5:4 and the captured beat index.

Top module: `errCaptureReg`

## Requirements
- R1: After reset, errStatus is all zero, locked is 0 and captureWord is zero.
- R2: When any errSet bit is high and the register is unlocked, the next cycle shows locked = 1, and captureWord holds the input values from the cycle of the error.
- R3: The capture word layout is as follows. Bits 31:25 hold the sequencer state. Bits 24:20 hold the data-cycle type. Bits 19:18 read zero. Bits 17:16 hold the beat index. Bits 15:8 hold the nonexistent-memory flags: bit 15 is translation-buffer fill, bit 14 is cache victim, bit 13 is I/O write, bit 12 is I/O read, bit 11 is CPU write, bit 10 is CPU read, bit 9 is DMA write and bit 8 is DMA read. Bits 7:0 hold address bits 39:32, of which only bits 1:0 (address 33:32) are meaningful.
- R4: While locked, new errors leave captureWord unchanged, and their errSet bits are ORed into errStatus.
- R5: A statusWrEn cycle clears each errStatus bit whose wrData bit is 1 and leaves the other bits alone. A bit raised by errSet in the same cycle stays set.
- R6: The register stays locked while any errStatus bit is set. It unlocks in the cycle after the last set bit is cleared.
- R7: If a new error arrives in the same cycle that clears the last status bit, the new error is captured and the register stays locked.
- R8: While locked, captureWrEn has no effect on any field of captureWord, including the sequencer-state field. That field is writable from wrData[31:25] only while unlocked.
- R9: failBeat equals (captured address bits 5:4 + captured beat index) mod 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| errSet | input | ERR_BITS | Error-status set pulses, one per source |
| seqState | input | 7 | Live sequencer state code |
| cycType | input | 5 | Live data-cycle type code |
| beatIdx | input | 2 | Live beat index within the burst |
| addrHi | input | 8 | Live address bits 39:32 |
| addrLo | input | 2 | Live address bits 5:4 |
| nxmFlags | input | 8 | Live nonexistent-memory event flags |
| statusWrEn | input | 1 | Write-one-to-clear strobe for errStatus |
| captureWrEn | input | 1 | Write strobe for the capture word |
| wrData | input | 32 | Bus write data |
| errStatus | output | ERR_BITS | Error-status bits |
| captureWord | output | 32 | Capture word for bus readback |
| locked | output | 1 | Capture word is frozen |
| failBeat | output | 2 | Low two location bits of the failing beat |

## Verification
A wrong lock state shows on `locked` one cycle after the cause. If the lock has opened when it should not, the next error overwrites `captureWord` one cycle later. If the lock is stuck, a new error after a full clear leaves a stale record. Status bits are compared every cycle, and so is the capture word whenever it is locked. A bad write-one-to-clear mask or a wrong set-versus-clear priority therefore shows within one cycle. The same-cycle clear-and-error case and writes during the lock are driven on purpose.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  typedef struct packed {
    logic capture;
    logic seqWr;
  } capStrobe_t;
endpackage

// File: rtl/errcap_ctrl.sv
module errcap_ctrl
  import errcap_pkg::*;
#(
  parameter int ERR_BITS = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ERR_BITS-1:0] errSet,
  input  logic                statusWrEn,
  input  logic                captureWrEn,
  input  logic [ERR_BITS-1:0] clrData,
  output logic [ERR_BITS-1:0] errStatus,
  output logic                locked,
  output capStrobe_t          stb
);
  logic [ERR_BITS-1:0] clrMask;
  logic [ERR_BITS-1:0] afterClr;
  logic [ERR_BITS-1:0] statusNext;
  logic                newErr;

  always_comb begin
    clrMask     = statusWrEn ? clrData : '0;
    afterClr    = errStatus & ~clrMask;
    newErr      = |errSet;
    statusNext  = afterClr | errSet;
    stb.capture = newErr && (!locked || afterClr == '0);
    stb.seqWr   = captureWrEn && !locked && !newErr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errStatus <= '0;
      locked    <= 1'b0;
    end else begin
      errStatus <= statusNext;
      locked    <= |statusNext;
    end
  end

  assert_err_locks_R2: assert property (@(posedge clk) disable iff (!rstN)
    newErr |=> locked);

  assert_w1c_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusWrEn && errSet == '0) |=> ((errStatus & $past(clrData)) == '0));

  assert_lock_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !statusWrEn) |=> locked);
endmodule

// File: rtl/errcap_dp.sv
module errcap_dp
  import errcap_pkg::*;
#(
  parameter int SEQ_W  = 7,
  parameter int TYPE_W = 5,
  parameter int IDX_W  = 2,
  parameter int NXM_W  = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  capStrobe_t        stb,
  input  logic              locked,
  input  logic [SEQ_W-1:0]  seqState,
  input  logic [TYPE_W-1:0] cycType,
  input  logic [IDX_W-1:0]  beatIdx,
  input  logic [ADDR_W-1:0] addrHi,
  input  logic [IDX_W-1:0]  addrLo,
  input  logic [NXM_W-1:0]  nxmFlags,
  input  logic [SEQ_W-1:0]  seqWrData,
  output logic [DATA_W-1:0] captureWord,
  output logic [IDX_W-1:0]  failBeat
);
  localparam int RSV_W = DATA_W - SEQ_W - TYPE_W - IDX_W - NXM_W - ADDR_W;

  logic [SEQ_W-1:0]  capSeq;
  logic [TYPE_W-1:0] capType;
  logic [IDX_W-1:0]  capIdx;
  logic [NXM_W-1:0]  capNxm;
  logic [ADDR_W-1:0] capHi;
  logic [IDX_W-1:0]  capLo;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capSeq  <= '0;
      capType <= '0;
      capIdx  <= '0;
      capNxm  <= '0;
      capHi   <= '0;
      capLo   <= '0;
    end else if (stb.capture) begin
      capSeq  <= seqState;
      capType <= cycType;
      capIdx  <= beatIdx;
      capNxm  <= nxmFlags;
      capHi   <= addrHi;
      capLo   <= addrLo;
    end else if (stb.seqWr) begin
      capSeq  <= seqWrData;
    end
  end

  always_comb begin
    captureWord = {capSeq, capType, {RSV_W{1'b0}}, capIdx, capNxm, capHi};
    failBeat    = capLo + capIdx;
  end

  assert_locked_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !stb.capture) |=> $stable(captureWord));
endmodule

// File: rtl/errCaptureReg.sv
module errCaptureReg
  import errcap_pkg::*;
#(
  parameter int ERR_BITS = 4,
  parameter int SEQ_W    = 7,
  parameter int TYPE_W   = 5,
  parameter int IDX_W    = 2,
  parameter int NXM_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ERR_BITS-1:0] errSet,
  input  logic [SEQ_W-1:0]    seqState,
  input  logic [TYPE_W-1:0]   cycType,
  input  logic [IDX_W-1:0]    beatIdx,
  input  logic [ADDR_W-1:0]   addrHi,
  input  logic [IDX_W-1:0]    addrLo,
  input  logic [NXM_W-1:0]    nxmFlags,
  input  logic                statusWrEn,
  input  logic                captureWrEn,
  input  logic [DATA_W-1:0]   wrData,
  output logic [ERR_BITS-1:0] errStatus,
  output logic [DATA_W-1:0]   captureWord,
  output logic                locked,
  output logic [IDX_W-1:0]    failBeat
);
  capStrobe_t stb;

  errcap_ctrl #(.ERR_BITS(ERR_BITS)) uCtrl (
    .clk(clk), .rstN(rstN), .errSet(errSet), .statusWrEn(statusWrEn),
    .captureWrEn(captureWrEn), .clrData(wrData[ERR_BITS-1:0]),
    .errStatus(errStatus), .locked(locked), .stb(stb)
  );

  errcap_dp #(.SEQ_W(SEQ_W), .TYPE_W(TYPE_W), .IDX_W(IDX_W), .NXM_W(NXM_W),
              .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .locked(locked),
    .seqState(seqState), .cycType(cycType), .beatIdx(beatIdx),
    .addrHi(addrHi), .addrLo(addrLo), .nxmFlags(nxmFlags),
    .seqWrData(wrData[DATA_W-1 -: SEQ_W]),
    .captureWord(captureWord), .failBeat(failBeat)
  );
endmodule

// File: tb/sim_errCaptureReg.sv
module sim_errCaptureReg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  errSet = '0;
  logic [6:0]  seqState = '0;
  logic [4:0]  cycType = '0;
  logic [1:0]  beatIdx = '0;
  logic [7:0]  addrHi = '0;
  logic [1:0]  addrLo = '0;
  logic [7:0]  nxmFlags = '0;
  logic        statusWrEn = 1'b0;
  logic        captureWrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0]  errStatus;
  logic [31:0] captureWord;
  logic        locked;
  logic [1:0]  failBeat;

  int total = 0;
  int bad = 0;

  // reference model state
  int mSt = 0, mLocked = 0, mSeq = 0, mType = 0, mIdx = 0, mNxm = 0, mHi = 0, mLo = 0;

  always #2 clk = ~clk;

  errCaptureReg u0 (.*);

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mLocked = 0; mSeq = 0; mType = 0; mIdx = 0; mNxm = 0; mHi = 0; mLo = 0;
    end else begin
      int clr, after;
      clr   = statusWrEn ? int'(wrData[3:0]) : 0;
      after = mSt & ~clr & 15;
      if (errSet != 0 && (mLocked == 0 || after == 0)) begin
        mSeq = seqState; mType = cycType; mIdx = beatIdx;
        mNxm = nxmFlags; mHi = addrHi; mLo = addrLo;
      end
      mSt     = after | int'(errSet);
      mLocked = (mSt != 0) ? 1 : 0;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] expWord();
    return {mSeq[6:0], mType[4:0], 2'b00, mIdx[1:0], mNxm[7:0], mHi[7:0]};
  endfunction

  task automatic compare();
    check("R5 R4 errStatus", {28'd0, errStatus}, mSt);
    check("R6 R2 locked", {31'd0, locked}, mLocked);
    if (mLocked != 0) begin
      check("R3 R4 R8 captureWord", captureWord & 32'hFFFF_FF03, expWord() & 32'hFFFF_FF03);
      check("R9 failBeat", {30'd0, failBeat}, (mLo + mIdx) % 4);
    end
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    errSet = '0; statusWrEn = 1'b0; captureWrEn = 1'b0; wrData = '0;
  endtask

  task automatic liveIn(int s, int t, int i, int h, int l, int n);
    seqState = 7'(s); cycType = 5'(t); beatIdx = 2'(i);
    addrHi = 8'(h); addrLo = 2'(l); nxmFlags = 8'(n);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset status", {28'd0, errStatus}, 32'd0);
    check("R1 reset locked", {31'd0, locked}, 32'd0);
    check("R1 reset word", captureWord, 32'd0);

    // R2/R3/R9 first error: CPU read nxm (bit 10), state 0x1C, type 0x01
    liveIn(7'h1C, 5'h01, 2, 8'hA3, 3, 8'h04);
    errSet = 4'b0001;
    step();
    check("R3 layout", captureWord, {7'h1C, 5'h01, 2'b00, 2'd2, 8'h04, 8'hA3});
    check("R9 beat wrap", {30'd0, failBeat}, 32'd1);

    // R4 second error while locked
    liveIn(7'h17, 5'h0D, 1, 8'h01, 0, 8'h02);
    errSet = 4'b0100;
    step();
    check("R4 no overwrite", captureWord, {7'h1C, 5'h01, 2'b00, 2'd2, 8'h04, 8'hA3});

    // R8 writes while locked
    captureWrEn = 1'b1; wrData = 32'hFFFF_FFFF;
    step();
    check("R8 locked write ignored", captureWord, {7'h1C, 5'h01, 2'b00, 2'd2, 8'h04, 8'hA3});

    // R5 partial clear with simultaneous set of a cleared bit
    statusWrEn = 1'b1; wrData = 32'h0000_0003; errSet = 4'b0010;
    step();
    check("R5 set beats clear", {28'd0, errStatus}, 32'h6);
    statusWrEn = 1'b1; wrData = 32'h0000_0002;
    step();
    check("R6 still locked", {31'd0, locked}, 32'd1);

    // R7 clear last bit and new error in same cycle
    liveIn(7'h0B, 5'h09, 3, 8'h02, 2, 8'h01);
    statusWrEn = 1'b1; wrData = 32'h0000_000F; errSet = 4'b1000;
    step();
    check("R7 new error captured", captureWord & 32'hFFFF_FF03,
          {7'h0B, 5'h09, 2'b00, 2'd3, 8'h01, 8'h02});
    check("R7 stays locked", {31'd0, locked}, 32'd1);

    // R6 full clear unlocks
    statusWrEn = 1'b1; wrData = 32'h0000_0008;
    step();
    check("R6 unlocked", {31'd0, locked}, 32'd0);

    // unlocked write then new error capture
    captureWrEn = 1'b1; wrData = 32'h5A00_0000;
    step();
    liveIn(7'h20, 5'h13, 0, 8'hFF, 1, 8'h40);
    errSet = 4'b0001;
    step();
    check("R2 recapture", captureWord & 32'hFFFF_FF03,
          {7'h20, 5'h13, 2'b00, 2'd0, 8'h40, 8'h03});

    // random traffic compared against the model every cycle
    for (int k = 0; k < 3000; k++) begin
      liveIn($urandom % 56, $urandom % 22, $urandom, $urandom, $urandom, 1 << ($urandom % 8));
      errSet      = (($urandom % 5) == 0) ? 4'($urandom) : 4'd0;
      statusWrEn  = (($urandom % 3) == 0);
      captureWrEn = (($urandom % 4) == 0);
      wrData      = $urandom;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule